// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers a vector of level-sensitive interrupt request lines (32 by default) into one interrupt output for a processor. Each line has a pending bit that tracks its request level, registered one cycle after the input. A software-controlled enable mask gates the pending bits. The interrupt output is high whenever a line is both pending and enabled.

Software reaches the block through a small memory-mapped port with 32-bit words. From there it can read how many interrupts are currently active, read the masked pending vector, and set or clear enable bits using write-one masks. A kill command turns off every enable bit and also wipes the pending vector. For debug, every line has a saturating counter of rising request edges. A separate index/data port reads these counters out.

The register port never stalls, so it has no back-pressure. A request is one cycle with `bus_sel` high. A write takes effect at that clock edge. A read returns its word in `bus_rdata` on the following cycle, and `bus_rdata` holds that word until the next read. The debug port has no handshake either: `dbg_cnt` shows, one cycle late, the counter selected by `dbg_idx`. Request inputs are assumed to be synchronous to `clk`.

Top module: `irq_agg_ctrl`

## Requirements
- R1: While `rst_n` is low, the pending vector, the enable mask, every event counter and `bus_rdata` are all cleared. After reset, `irq_out`, `bus_rdata` and `dbg_cnt` read zero.
- R2: A line's pending bit is a copy of its request level, taken at each clock edge. It is set while the level is high and cleared once the level is low.
- R3: `irq_out` is high exactly when (pending AND enable) is non-zero. It follows register changes with no further delay.
- R4: A read at byte offset 0x00 returns the number of set bits in (pending AND enable), a value from 0 to the line count.
- R5: A read at byte offset 0x04 returns pending AND enable, not the raw pending vector.
- R6: A write to byte offset 0x10 ORs the write data into the enable mask.
- R7: A write to byte offset 0x0C clears each enable bit where the write data has a one, and leaves the other enable bits unchanged.
- R8: A write to byte offset 0x08 clears both the enable mask and the pending vector, whatever the write data is. On the next clock edge, pending again copies the request levels.
- R9: The register window is 0x24 bytes. The following have no effect on any state: a misaligned access (address bits [1:0] not zero), an access outside the window, a write to offsets 0x00 or 0x04, and a write to an unused offset. A read in any of these cases returns zero.
- R10: Each line's event counter counts rising edges of its request input and saturates at all ones. The kill command does not clear the counters. `dbg_cnt` shows, one cycle later, the counter chosen by `dbg_idx`.
- R11: A read returns its data in `bus_rdata` on the cycle after the request. `bus_rdata` then keeps its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_req | input | 32 | Level-sensitive request lines |
| irq_out | output | 1 | Combined interrupt to the processor |
| bus_sel | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_idx | input | 5 | Line whose event counter is shown |
| dbg_cnt | output | 32 | Registered event count of the selected line |

## Verification
The hardest condition to reach from the ports is a saturated event counter. The bench therefore builds the block with narrow counters and toggles one line well past the counter's limit, then reads it back through the debug port. A second hard case is a kill command issued while requests are still high. Pending must drop for exactly one cycle and then reload, while the enable mask stays clear. Directed steps cover this case, and random phases also mix kill writes with random request levels, random mask writes and accesses to misaligned or out-of-window addresses.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Word indices inside the register window (byte offset / 4).
  localparam int unsigned WORD_STATUS  = 0;
  localparam int unsigned WORD_ACTIVE  = 1;
  localparam int unsigned WORD_KILL    = 2;
  localparam int unsigned WORD_MASKCLR = 3;
  localparam int unsigned WORD_MASKSET = 4;
  // Window of 0x24 bytes holds nine words.
  localparam int unsigned WINDOW_WORDS = 9;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_KILL,
    OP_MASKCLR,
    OP_MASKSET
  } wr_op_e;
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic               wipe_i,
  output logic [N_LINES-1:0] pend_o,
  output logic [N_LINES-1:0] rise_o
);
  logic [N_LINES-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_o[g] <= 1'b0;
          prev_q[g] <= 1'b0;
        end else begin
          pend_o[g] <= wipe_i ? 1'b0 : req_i[g];
          prev_q[g] <= req_i[g];
        end
      end
      assign rise_o[g] = req_i[g] & ~prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  irq_agg_pkg::wr_op_e op_i,
  input  logic [N_LINES-1:0] data_i,
  output logic [N_LINES-1:0] en_o
);
  import irq_agg_pkg::*;

  logic [N_LINES-1:0] en_d;

  always_comb begin
    en_d = en_o;
    unique case (op_i)
      OP_KILL:    en_d = '0;
      OP_MASKCLR: en_d = en_o & ~data_i;
      OP_MASKSET: en_d = en_o | data_i;
      default:    en_d = en_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_o <= '0;
    else        en_o <= en_d;
  end
endmodule

// File: rtl/irq_event_counters.sv
module irq_event_counters #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned CNT_W   = 32,
  localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] rise_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [N_LINES-1:0][CNT_W-1:0] cnt_q;

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n)
          cnt_q[g] <= '0;
        else if (rise_i[g] && (cnt_q[g] != CNT_MAX))
          cnt_q[g] <= cnt_q[g] + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= (32'(idx_i) < N_LINES) ? cnt_q[idx_i] : '0;
  end
endmodule

// File: rtl/irq_popcount.sv
module irq_popcount #(
  parameter int unsigned N_LINES = 32,
  localparam int unsigned OUT_W  = $clog2(N_LINES + 1)
) (
  input  logic [N_LINES-1:0] vec_i,
  output logic [OUT_W-1:0]   cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N_LINES; i++)
      cnt_o = cnt_o + OUT_W'(vec_i[i]);
  end
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned CNT_W   = 32,
  localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int unsigned POP_W  = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  output logic               irq_out,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [IDX_W-1:0]   dbg_idx,
  output logic [CNT_W-1:0]   dbg_cnt
);
  import irq_agg_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [N_LINES-1:0] pend, en, rise, active;
  logic [POP_W-1:0]   active_cnt;
  logic [WORD_W-1:0]  word;
  logic               aligned, in_window, rd_req;
  wr_op_e             op;
  logic [DATA_W-1:0]  rd_val;

  assign word      = bus_addr[ADDR_W-1:2];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign in_window = aligned && (32'(word) < WINDOW_WORDS);
  assign rd_req    = bus_sel && !bus_we;

  // Write decode
  always_comb begin
    op = OP_NONE;
    if (bus_sel && bus_we && in_window) begin
      case (32'(word))
        WORD_KILL:    op = OP_KILL;
        WORD_MASKCLR: op = OP_MASKCLR;
        WORD_MASKSET: op = OP_MASKSET;
        default:      op = OP_NONE;
      endcase
    end
  end

  irq_line_bank #(.N_LINES(N_LINES)) u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_req),
    .wipe_i (op == OP_KILL),
    .pend_o (pend),
    .rise_o (rise)
  );

  irq_mask_reg #(.N_LINES(N_LINES)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op),
    .data_i (bus_wdata[N_LINES-1:0]),
    .en_o   (en)
  );

  irq_event_counters #(.N_LINES(N_LINES), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (rise),
    .idx_i  (dbg_idx),
    .cnt_o  (dbg_cnt)
  );

  assign active = pend & en;

  irq_popcount #(.N_LINES(N_LINES)) u_pop (
    .vec_i (active),
    .cnt_o (active_cnt)
  );

  assign irq_out = |active;

  // Read mux
  always_comb begin
    rd_val = '0;
    if (in_window) begin
      case (32'(word))
        WORD_STATUS: rd_val = DATA_W'(active_cnt);
        WORD_ACTIVE: rd_val = DATA_W'(active);
        default:     rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/irq_agg_ctrl_chk.sv
module irq_agg_ctrl_chk #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] irq_req,
  input logic               irq_out,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata
);
  logic kill_wr, clrall_wr, rd;
  assign kill_wr   = bus_sel && bus_we && (bus_addr == ADDR_W'(8));
  assign clrall_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(12)) && (&bus_wdata);
  assign rd        = bus_sel && !bus_we;

  assert_quiet_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == '0) |=> !irq_out);

  assert_kill_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_wr |=> !irq_out);

  assert_clear_all_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clrall_wr |=> !irq_out);

  assert_status_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == '0) |=> (bus_rdata <= DATA_W'(N_LINES)));

  assert_misaligned_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

bind irq_agg_ctrl irq_agg_ctrl_chk #(
  .N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_out(irq_out),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/tb_irq_agg_ctrl.sv
module tb_irq_agg_ctrl;
  localparam int TCLK  = 10;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_req;
  logic        irq_out;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [4:0]  dbg_idx;
  logic [CNT_W-1:0] dbg_cnt;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_pend, m_en, m_prev, m_rdata;
  int          m_cnt [32];

  always #(TCLK/2) clk = ~clk;

  irq_agg_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_out(irq_out),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_idx(dbg_idx), .dbg_cnt(dbg_cnt)
  );

  function automatic int popc(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a == 6'h00) return 32'(popc(m_pend & m_en));
    if (a == 6'h04) return m_pend & m_en;
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle, checks at the next falling edge.
  task automatic step(input bit sel, input bit we, input logic [5:0] a,
                      input logic [31:0] wd, input logic [31:0] req,
                      input logic [4:0] idx, input string tag);
    logic [31:0] exp_rd, rise;
    int exp_dbg;
    bit kill;
    irq_req = req; bus_sel = sel; bus_we = we; bus_addr = a;
    bus_wdata = wd; dbg_idx = idx;
    exp_rd  = (sel && !we) ? model_read(a) : m_rdata;
    exp_dbg = m_cnt[idx];
    kill    = sel && we && a == 6'h08;
    @(posedge clk);
    m_rdata = exp_rd;
    if (kill) m_en = 32'h0;
    else if (sel && we && a == 6'h0C) m_en = m_en & ~wd;
    else if (sel && we && a == 6'h10) m_en = m_en | wd;
    m_pend = kill ? 32'h0 : req;
    rise = req & ~m_prev;
    m_prev = req;
    for (int i = 0; i < 32; i++)
      if (rise[i] && m_cnt[i] < CMAX) m_cnt[i]++;
    @(negedge clk);
    check(irq_out == (|(m_pend & m_en)), {"R3 irq_out ", tag},
          32'(irq_out), 32'(|(m_pend & m_en)));
    check(bus_rdata == m_rdata, {"R11 rdata ", tag}, bus_rdata, m_rdata);
    check(int'(dbg_cnt) == exp_dbg, {"R10 dbg_cnt ", tag}, 32'(dbg_cnt), 32'(exp_dbg));
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] req, input string tag);
    step(1'b1, 1'b0, a, 32'h0, req, 5'd0, tag);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [31:0] req,
                    input string tag);
    step(1'b1, 1'b1, a, d, req, 5'd0, tag);
  endtask

  initial begin
    #(TCLK * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; irq_req = 32'hFFFF_FFFF; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; dbg_idx = '0;
    m_pend = 0; m_en = 0; m_prev = 0; m_rdata = 0;
    for (int i = 0; i < 32; i++) m_cnt[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    irq_req = 32'h0;
    rst_n = 1'b1;
    // R1: reset state
    check(irq_out == 1'b0, "R1 irq_out after reset", 32'(irq_out), 0);
    check(bus_rdata == 0, "R1 rdata after reset", bus_rdata, 0);
    check(dbg_cnt == 0, "R1 dbg_cnt after reset", 32'(dbg_cnt), 0);
    rd(6'h00, 32'h0, "R1 status zero");
    check(bus_rdata == 0, "R1 status read", bus_rdata, 0);

    // R2/R5: pending tracks level but stays hidden while disabled
    rd(6'h04, 32'h0000_00F0, "R5 masked hidden");
    check(bus_rdata == 0, "R5 disabled lines read zero", bus_rdata, 0);
    wr(6'h10, 32'h0000_0030, 32'h0000_00F0, "R6 set enable");
    rd(6'h04, 32'h0000_00F0, "R5 masked visible");
    check(bus_rdata == 32'h30, "R5 pending AND enable", bus_rdata, 32'h30);
    rd(6'h00, 32'h0000_00F0, "R4 popcount");
    check(bus_rdata == 2, "R4 count of two", bus_rdata, 2);
    wr(6'h10, 32'h0000_0040, 32'h0000_00F0, "R6 OR in");
    wr(6'h0C, 32'h0000_0010, 32'h0000_00F0, "R7 clear one");
    rd(6'h04, 32'h0000_00F0, "R7 readback");
    check(bus_rdata == 32'h60, "R7 only bit 4 cleared", bus_rdata, 32'h60);
    step(1'b0, 1'b0, 6'h00, 0, 32'h0, 5'd0, "R2 level low");
    check(irq_out == 1'b0, "R2 pending cleared on low level", 32'(irq_out), 0);

    // R9: writes to read-only, unused, misaligned and out-of-window offsets
    wr(6'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 write status");
    wr(6'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 write pending");
    wr(6'h11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 misaligned set");
    wr(6'h30, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 out of window");
    wr(6'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 unused");
    rd(6'h04, 32'hFFFF_FFFF, "R9 mask unchanged");
    check(bus_rdata == 32'h60, "R9 enable unchanged", bus_rdata, 32'h60);
    rd(6'h20, 32'hFFFF_FFFF, "R9 unused read");
    check(bus_rdata == 0, "R9 unused offset reads zero", bus_rdata, 0);
    rd(6'h06, 32'hFFFF_FFFF, "R9 misaligned read");

    // R8: kill with requests high; all-ones status first
    wr(6'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 all on");
    rd(6'h00, 32'hFFFF_FFFF, "R4 full");
    check(bus_rdata == 32, "R4 count reaches 32", bus_rdata, 32);
    wr(6'h08, 32'h0, 32'hFFFF_FFFF, "R8 kill");
    check(irq_out == 1'b0, "R8 output low after kill", 32'(irq_out), 0);
    wr(6'h10, 32'h0000_0001, 32'hFFFF_FFFF, "R8 pending reloads");
    check(irq_out == 1'b1, "R8 pending reloaded next edge", 32'(irq_out), 1);

    // R10: saturate line 5
    for (int k = 0; k < 20; k++) begin
      step(1'b0, 1'b0, 0, 0, 32'h0000_0020, 5'd5, "R10 toggle hi");
      step(1'b0, 1'b0, 0, 0, 32'h0, 5'd5, "R10 toggle lo");
    end
    wr(6'h08, 32'hDEAD_BEEF, 32'h0, "R10 kill keeps counters");
    step(1'b0, 1'b0, 0, 0, 32'h0, 5'd5, "R10 idle");
    step(1'b0, 1'b0, 0, 0, 32'h0, 5'd5, "R10 sat read");
    check(int'(dbg_cnt) == CMAX, "R10 saturated counter", 32'(dbg_cnt), CMAX);

    // Random phase
    r = 32'h0;
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] a;
      int pick;
      bit s, w;
      if ($urandom_range(0, 3) == 0) r = $urandom();
      pick = $urandom_range(0, 9);
      case (pick)
        0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h08; 3: a = 6'h0C;
        4, 5: a = 6'h10; 6: a = 6'(4 * $urandom_range(5, 15));
        7: a = 6'($urandom()); default: a = 6'h04;
      endcase
      s = ($urandom_range(0, 3) != 0);
      w = (a == 6'h08) ? ($urandom_range(0, 7) == 0) : $urandom_range(0, 1) == 1;
      step(s, w, a, $urandom(), r, 5'($urandom()), "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule